// File: doc/BRIEF.md
# MDIO Management Register Controller

This block is a management-bus master for Ethernet PHYs. Software addresses it through a two-word register window with a single write strobe. One word is the control word: it holds a PHY address, a register address, two command bits, and a data field. The other word holds the value that a write operation sends. Writing the control word with a command bit set starts a Clause 22 management frame. The block shifts the frame out on MDC and MDIO, using a clock divider it owns.

A command bit stays high as long as the frame is in flight and drops by itself once the frame ends. Software therefore polls the control word to learn when an operation is finished. After a read, the sixteen bits returned by the PHY are placed in the low field of the same control word. One operation takes 128 half-periods of MDC. With the default divider at a 50 MHz system clock, that is about 10 µs, well inside a millisecond-scale polling budget.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, the control word (bus_addr 0) and the write-data word (bus_addr 1) both read as zero, MDC is low and the MDIO output enable is low.
- R2: Writing the control word with bit 27 set and bit 26 clear starts a write. Bits 25:21 carry the PHY address and bits 20:16 the register address. The block then drives 64 bits MSB first, with each bit presented before the MDC rising edge that samples it: 32 ones, 01, opcode 01, PHY address, register address, turnaround 10, then the low 16 bits of the write-data word. The output enable stays high for all 64 bits.
- R3: Writing the control word with bit 26 set starts a read. The block drives 46 bits: 32 ones, 01, opcode 10, PHY address and register address. It then drops the output enable for the remaining 18 bit times, which are the two turnaround bits and 16 data bits.
- R4: During a read, the block samples MDIO on the rising MDC edge of each of the last 16 bit times, MSB first. The result appears in control-word bits 15:0 when the command completes. A PHY that does not answer leaves the line pulled high, so the result is 16'hFFFF.
- R5: The command bit reads back as set from the clock edge that accepts the start write. It clears exactly 128*DIV_HALF+1 clock cycles after that edge.
- R6: Each MDC phase lasts DIV_HALF system clocks while a frame is in flight. MDC is low whenever no command bit is set.
- R7: If bits 26 and 27 are both set in the start write, a read is performed. Only bit 26 reads back as set, and the register named in the command is not written.
- R8: A write to the control word while a command is in progress is ignored. The addresses and command of the running frame are unchanged, and no second frame follows.
- R9: Bits 15:0 of the control word cannot be written from the bus. A control write with bits 27:26 both zero updates only the two address fields and does not start a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Word select: 0 control, 1 write data |
| bus_wdata | input | 28 | Register write data |
| bus_rdata | output | 28 | Contents of the selected word |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven by the block |
| mdio_oe | output | 1 | Output enable for mdio_o |
| mdio_i | input | 1 | Management data seen on the pin |

## Verification
The assertions assume that software writes at most one word per cycle and issues a new command only after the current command bit has cleared. The one exception is the deliberate write made during a busy frame. They also assume that the returned MDIO bit is stable around each rising MDC edge. The bench meets these conditions with a PHY model that changes its output only on falling MDC edges and otherwise lets a pull-up hold the line high. The bench launches each command only after polling the control word to idle. It makes exactly one write during a busy period, and that write is the one the R8 check is built around.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    // Frame geometry of a Clause 22 management transaction
    localparam int PRE_LEN   = 32;
    localparam int ADDR_W    = 5;
    localparam int DATA_W    = 16;
    localparam int FRAME_LEN = PRE_LEN + 2 + 2 + 2 * ADDR_W + 2 + DATA_W;
    localparam int TA_POS    = PRE_LEN + 4 + 2 * ADDR_W;   // first turnaround bit
    localparam int RDATA_POS = TA_POS + 2;                  // first returned data bit

    // Register window
    localparam int  WORD_W     = DATA_W + 2 * ADDR_W + 2;
    localparam int  HI_W       = WORD_W - DATA_W;
    localparam logic ADDR_CTRL  = 1'b0;
    localparam logic ADDR_WDATA = 1'b1;

    // Opcode values double as the frame's opcode field
    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10
    } mdio_op_e;

    typedef struct packed {
        mdio_op_e           op;
        logic [ADDR_W-1:0]  phy;
        logic [ADDR_W-1:0]  regad;
    } mdio_cmd_t;

    // Upper control field: [11] write, [10] read, [9:5] phy, [4:0] register.
    // Read wins when both command bits are set.
    function automatic mdio_cmd_t decode_cmd(input logic [HI_W-1:0] hi);
        mdio_cmd_t c;
        c.phy   = hi[2*ADDR_W-1:ADDR_W];
        c.regad = hi[ADDR_W-1:0];
        if (hi[HI_W-2])      c.op = OP_READ;
        else if (hi[HI_W-1]) c.op = OP_WRITE;
        else                 c.op = OP_NONE;
        return c;
    endfunction

    function automatic logic [FRAME_LEN-1:0] build_frame(input mdio_cmd_t c,
                                                         input logic [DATA_W-1:0] wd);
        logic [DATA_W-1:0] tail;
        tail = (c.op == OP_WRITE) ? wd : {DATA_W{1'b1}};
        return {{PRE_LEN{1'b1}}, 2'b01, c.op, c.phy, c.regad, 2'b10, tail};
    endfunction

endpackage

// File: rtl/mdio_mgmt_clkgen.sv
module mdio_mgmt_clkgen #(
    parameter int DIV_HALF = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CNT_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV_HALF - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             mdc_q;
    logic             wrap;

    assign wrap      = en && (cnt_q == CNT_LAST);
    assign rise_tick = wrap && !mdc_q;
    assign fall_tick = wrap && mdc_q;
    assign mdc       = mdc_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/mdio_mgmt_engine.sv
module mdio_mgmt_engine
    import mdio_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  mdio_cmd_t         cmd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              mdio_i,
    output logic              active,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              mdio_o,
    output logic              mdio_oe
);
    localparam int IDX_W = $clog2(FRAME_LEN);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_LEN - 1);
    localparam logic [IDX_W-1:0] IDX_TA   = IDX_W'(TA_POS);
    localparam logic [IDX_W-1:0] IDX_RD   = IDX_W'(RDATA_POS);

    logic [FRAME_LEN-1:0] frame_q;
    logic [IDX_W-1:0]     idx_q;
    logic                 is_rd_q;
    logic                 active_q;
    logic                 done_q;
    logic [DATA_W-1:0]    rsh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q  <= '0;
            idx_q    <= '0;
            is_rd_q  <= 1'b0;
            active_q <= 1'b0;
            done_q   <= 1'b0;
            rsh_q    <= '0;
        end else begin
            done_q <= 1'b0;
            if (start && !active_q) begin
                frame_q  <= build_frame(cmd, wdata);
                idx_q    <= '0;
                is_rd_q  <= (cmd.op == OP_READ);
                active_q <= 1'b1;
            end else if (active_q) begin
                if (rise_tick && is_rd_q && (idx_q >= IDX_RD))
                    rsh_q <= {rsh_q[DATA_W-2:0], mdio_i};
                if (fall_tick) begin
                    frame_q <= {frame_q[FRAME_LEN-2:0], 1'b0};
                    if (idx_q == IDX_LAST) begin
                        active_q <= 1'b0;
                        done_q   <= 1'b1;
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                    end
                end
            end
        end
    end

    assign active  = active_q;
    assign done    = done_q;
    assign rdata   = rsh_q;
    assign mdio_oe = active_q && (!is_rd_q || (idx_q < IDX_TA));
    assign mdio_o  = mdio_oe && frame_q[FRAME_LEN-1];
endmodule

// File: rtl/mdio_mgmt_regs.sv
module mdio_mgmt_regs
    import mdio_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic              eng_done,
    input  logic [DATA_W-1:0] eng_rdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic [WORD_W-1:0] ctrl_word,
    output logic              start,
    output mdio_cmd_t         start_cmd,
    output logic [DATA_W-1:0] wdata
);
    logic [ADDR_W-1:0] phy_q;
    logic [ADDR_W-1:0] reg_q;
    logic              rd_q;
    logic              wr_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] wdata_q;
    logic              busy;
    logic              ctrl_wr;

    assign busy      = rd_q || wr_q;
    assign ctrl_wr   = bus_wr && (bus_addr == ADDR_CTRL) && !busy;
    assign start_cmd = decode_cmd(bus_wdata[WORD_W-1:DATA_W]);
    assign start     = ctrl_wr && (start_cmd.op != OP_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phy_q   <= '0;
            reg_q   <= '0;
            rd_q    <= 1'b0;
            wr_q    <= 1'b0;
            data_q  <= '0;
            wdata_q <= '0;
        end else begin
            if (eng_done) begin
                if (rd_q) data_q <= eng_rdata;
                rd_q <= 1'b0;
                wr_q <= 1'b0;
            end
            if (bus_wr && (bus_addr == ADDR_WDATA))
                wdata_q <= bus_wdata[DATA_W-1:0];
            if (ctrl_wr) begin
                phy_q <= start_cmd.phy;
                reg_q <= start_cmd.regad;
                rd_q  <= (start_cmd.op == OP_READ);
                wr_q  <= (start_cmd.op == OP_WRITE);
            end
        end
    end

    assign ctrl_word = {wr_q, rd_q, phy_q, reg_q, data_q};
    assign wdata     = wdata_q;
    assign bus_rdata = (bus_addr == ADDR_WDATA) ? {{(WORD_W-DATA_W){1'b0}}, wdata_q}
                                                : ctrl_word;
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_mgmt_pkg::*;
#(
    parameter int DIV_HALF = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    logic              start;
    mdio_cmd_t         start_cmd;
    logic [DATA_W-1:0] wdata;
    logic [WORD_W-1:0] ctrl_word;
    logic              eng_active;
    logic              eng_done;
    logic [DATA_W-1:0] eng_rdata;
    logic              rise_tick;
    logic              fall_tick;

    mdio_mgmt_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .eng_done  (eng_done),
        .eng_rdata (eng_rdata),
        .bus_rdata (bus_rdata),
        .ctrl_word (ctrl_word),
        .start     (start),
        .start_cmd (start_cmd),
        .wdata     (wdata)
    );

    mdio_mgmt_clkgen #(.DIV_HALF(DIV_HALF)) u_clkgen (
        .clk       (clk),
        .rst       (rst),
        .en        (eng_active),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_mgmt_engine u_engine (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cmd       (start_cmd),
        .wdata     (wdata),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_i    (mdio_i),
        .active    (eng_active),
        .done      (eng_done),
        .rdata     (eng_rdata),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe)
    );
endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
module mdio_mgmt_ctrl_chk
    import mdio_mgmt_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            mdc,
    input logic            mdio_oe,
    input logic [HI_W-1:0] ctl_hi,
    input logic            eng_done
);
    logic busy;
    assign busy = ctl_hi[HI_W-1] || ctl_hi[HI_W-2];

    // R6
    idle_mdc_low_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdc);

    // R3
    oe_needs_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        mdio_oe |-> busy);

    // R7
    single_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        !(ctl_hi[HI_W-1] && ctl_hi[HI_W-2]));

    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(ctl_hi));

    // R5
    clear_on_done_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(eng_done));
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .mdc      (mdc),
    .mdio_oe  (mdio_oe),
    .ctl_hi   (ctrl_word[mdio_mgmt_pkg::WORD_W-1:mdio_mgmt_pkg::DATA_W]),
    .eng_done (eng_done)
);

// File: tb/mdio_mgmt_ctrl_test.sv
module mdio_mgmt_ctrl_test;
    localparam int DIV_HALF = 4;
    localparam int EXP_CYC  = 128 * DIV_HALF + 1;
    localparam logic [4:0] PHY_ADDR = 5'd9;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_addr = 1'b0;
    logic [27:0] bus_wdata = '0;
    logic [27:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    mdio_mgmt_ctrl #(.DIV_HALF(DIV_HALF)) uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // ---------------- PHY model ----------------
    logic [15:0] phy_mem [32];
    logic [63:0] cap = '0, last_cap = '0;
    logic [63:0] oe_hist = '0, last_oe = '0;
    int          rise_cnt = 0;
    logic        phy_drv = 1'b0;
    logic        phy_bit = 1'b1;

    function automatic logic [15:0] init_val(input int i);
        return 16'h5A00 + 16'(i * 273);
    endfunction

    initial for (int i = 0; i < 32; i++) phy_mem[i] = init_val(i);

    assign mdio_i = phy_drv ? phy_bit : (mdio_oe ? mdio_o : 1'b1);

    always @(posedge mdc) begin
        cap[63 - rise_cnt]  = mdio_oe ? mdio_o : 1'b1;
        oe_hist[rise_cnt]   = mdio_oe;
        if (rise_cnt == 63) begin
            if (cap[29:28] == 2'b01 && cap[27:23] == PHY_ADDR)
                phy_mem[cap[22:18]] = cap[15:0];
            last_cap = cap;
            last_oe  = oe_hist;
            rise_cnt = 0;
        end else begin
            rise_cnt = rise_cnt + 1;
        end
    end

    always @(negedge mdc) begin
        if (rise_cnt >= 48 && rise_cnt <= 63 && cap[29:28] == 2'b10
            && cap[27:23] == PHY_ADDR) begin
            phy_drv = 1'b1;
            phy_bit = phy_mem[cap[22:18]][63 - rise_cnt];
        end else begin
            phy_drv = 1'b0;
        end
    end

    // ---------------- MDC phase monitor ----------------
    logic mdc_prev = 1'b0;
    int   run = 0;
    int   half_seen = 0;
    int   half_bad = 0;
    always @(negedge clk) begin
        if (mdc !== mdc_prev) begin
            if (mdc_prev == 1'b1 || rise_cnt > 1) begin
                half_seen++;
                if (run != DIV_HALF) half_bad++;
            end
            run = 1;
        end else begin
            run++;
        end
        mdc_prev = mdc;
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic [27:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 1'b0;
    endtask

    function automatic logic [27:0] ctl(input bit wr, input bit rd,
                                        input logic [4:0] phy, input logic [4:0] ra);
        return {wr, rd, phy, ra, 16'h0000};
    endfunction

    // Launch a command and poll until its bits clear; optional busy write.
    task automatic run_op(input logic [27:0] word, input bit poke, output int cyc);
        @(negedge clk);
        bus_addr = 1'b0; bus_wdata = word; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        cyc = 0;
        while (bus_rdata[27:26] != 2'b00 && cyc < 4 * EXP_CYC) begin
            if (poke && cyc == 20) begin
                bus_wdata = ctl(1'b0, 1'b1, 5'd30, 5'd30);
                bus_wr = 1'b1;
            end else begin
                bus_wr = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        bus_wr = 1'b0;
    endtask

    function automatic logic [15:0] wval(input int r);
        return 16'hC3A5 ^ 16'(r * 16'h0421);
    endfunction

    function automatic logic [63:0] wr_frame(input logic [4:0] p, input logic [4:0] r,
                                              input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, 2'b01, p, r, 2'b10, d};
    endfunction

    function automatic logic [45:0] rd_head(input logic [4:0] p, input logic [4:0] r);
        return {32'hFFFF_FFFF, 2'b01, 2'b10, p, r};
    endfunction

    localparam logic [63:0] OE_READ = (64'd1 << 46) - 64'd1;

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // ---------------- main ----------------
    initial begin
        int cyc;
        int idle_hi;
        logic [63:0] snap;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        bus_addr = 1'b0; #1;
        chk(bus_rdata == 28'h0, "R1 ctrl reset", 64'(bus_rdata), 64'h0);
        bus_addr = 1'b1; #1;
        chk(bus_rdata == 28'h0, "R1 wdata reset", 64'(bus_rdata), 64'h0);
        bus_addr = 1'b0;
        chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins idle",
            64'({mdc, mdio_oe}), 64'h0);

        // Sweep every register: write then read back (R2 R3 R4 R5)
        for (int r = 0; r < 32; r++) begin
            bus_write(1'b1, {12'h000, wval(r)});
            run_op(ctl(1'b1, 1'b0, PHY_ADDR, 5'(r)), 1'b0, cyc);
            chk(cyc == EXP_CYC, "R5 write latency", 64'(cyc), 64'(EXP_CYC));
            chk(last_cap == wr_frame(PHY_ADDR, 5'(r), wval(r)), "R2 write frame",
                last_cap, wr_frame(PHY_ADDR, 5'(r), wval(r)));
            chk(last_oe == 64'hFFFF_FFFF_FFFF_FFFF, "R2 write enable",
                last_oe, 64'hFFFF_FFFF_FFFF_FFFF);

            run_op(ctl(1'b0, 1'b1, PHY_ADDR, 5'(r)), 1'b0, cyc);
            chk(cyc == EXP_CYC, "R5 read latency", 64'(cyc), 64'(EXP_CYC));
            chk(last_cap[63:18] == rd_head(PHY_ADDR, 5'(r)), "R3 read header",
                64'(last_cap[63:18]), 64'(rd_head(PHY_ADDR, 5'(r))));
            chk(last_oe == OE_READ, "R3 read release", last_oe, OE_READ);
            chk(bus_rdata[15:0] == wval(r), "R4 read data",
                64'(bus_rdata[15:0]), 64'(wval(r)));
            chk(bus_rdata[25:16] == {PHY_ADDR, 5'(r)}, "R4 address kept",
                64'(bus_rdata[25:16]), 64'({PHY_ADDR, 5'(r)}));
        end

        // Sweep PHY addresses on register 3: only PHY_ADDR answers (R4)
        for (int p = 0; p < 32; p++) begin
            logic [15:0] exp_v;
            exp_v = (5'(p) == PHY_ADDR) ? wval(3) : 16'hFFFF;
            run_op(ctl(1'b0, 1'b1, 5'(p), 5'd3), 1'b0, cyc);
            chk(bus_rdata[15:0] == exp_v, "R4 phy sweep",
                64'(bus_rdata[15:0]), 64'(exp_v));
        end

        // R7: both command bits -> read, register not written
        bus_write(1'b1, 28'h0000_1234);
        @(negedge clk);
        bus_addr = 1'b0; bus_wdata = ctl(1'b1, 1'b1, PHY_ADDR, 5'd7); bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        chk(bus_rdata[27:26] == 2'b01, "R7 read bit only",
            64'(bus_rdata[27:26]), 64'h1);
        cyc = 0;
        while (bus_rdata[27:26] != 2'b00 && cyc < 4 * EXP_CYC) begin
            @(negedge clk); cyc++;
        end
        chk(last_cap[29:28] == 2'b10, "R7 read opcode", 64'(last_cap[29:28]), 64'h2);
        chk(bus_rdata[15:0] == wval(7), "R7 register untouched",
            64'(bus_rdata[15:0]), 64'(wval(7)));

        // R8: control write during a busy write is ignored
        bus_write(1'b1, 28'h0000_0F0F);
        run_op(ctl(1'b1, 1'b0, PHY_ADDR, 5'd12), 1'b1, cyc);
        chk(cyc == EXP_CYC, "R8 latency unchanged", 64'(cyc), 64'(EXP_CYC));
        chk(last_cap == wr_frame(PHY_ADDR, 5'd12, 16'h0F0F), "R8 frame intact",
            last_cap, wr_frame(PHY_ADDR, 5'd12, 16'h0F0F));
        chk(bus_rdata[25:16] == {PHY_ADDR, 5'd12}, "R8 fields intact",
            64'(bus_rdata[25:16]), 64'({PHY_ADDR, 5'd12}));
        snap = last_cap;
        idle_hi = 0;
        for (int i = 0; i < 3 * EXP_CYC; i++) begin
            @(negedge clk);
            if (mdc || mdio_oe) idle_hi++;
        end
        chk(idle_hi == 0 && last_cap == snap, "R8 no second frame",
            64'(idle_hi), 64'h0);

        // R9: data field read-only, no-command write only moves addresses
        snap = 64'(bus_rdata[15:0]);
        bus_write(1'b0, {2'b00, 5'd17, 5'd21, 16'hBEEF});
        #1;
        chk(bus_rdata[15:0] == snap[15:0], "R9 data field read-only",
            64'(bus_rdata[15:0]), snap);
        chk(bus_rdata[27:16] == {2'b00, 5'd17, 5'd21}, "R9 address update",
            64'(bus_rdata[27:16]), 64'({2'b00, 5'd17, 5'd21}));
        idle_hi = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (mdc || mdio_oe) idle_hi++;
        end
        // R6 idle low as well
        chk(idle_hi == 0, "R9 R6 no frame started", 64'(idle_hi), 64'h0);

        // R6 phase length across all frames
        chk(half_seen > 0 && half_bad == 0, "R6 mdc phase length",
            64'(half_bad), 64'h0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule